// File: doc/BRIEF.md
# Float to Integer Conversion Unit

This block turns an IEEE-754 floating-point operand into a 32-bit integer, either signed or unsigned. The operand arrives on a 64-bit field. A precision select says whether the field holds a double, or a single-precision value in its low 32 bits. Single values are widened to double layout, so one datapath handles both precisions. The result is registered and appears one cycle after the request.

Rounding comes from a 2-bit mode field, which the surrounding logic takes from bits 23:22 of its floating-point status/control word. A force-toward-zero input overrides that field. Round-to-nearest-even, round-toward-minus-infinity and round-toward-zero are supported. The plus-infinity encoding is reported as an error, and the round-toward-zero result is returned in its place.

The magnitude is rounded first, using guard and sticky bits. The carry out of the rounding step is then checked against limits that depend on the signedness and on the direction of the value. A NaN or an out-of-range value raises the invalid flag and returns a fixed saturation value.

Top module: `fcvt_to_int`

## Requirements
- R1: While rst_n is low and after it is released with no request, out_valid, result, invalid and mode_err are all 0.
- R2: A request taken with in_valid high appears on result, invalid and mode_err in the next cycle, with out_valid high in that cycle only. When in_valid is low, out_valid is low in the next cycle.
- R3: When force_rz is 1, round toward zero is used whatever rmode holds. When force_rz is 0, rmode selects the rounding: 00 nearest-even, 10 toward minus infinity, 11 toward zero.
- R4: In nearest-even mode, a discarded fraction of exactly one half rounds to the even integer. A fraction above one half rounds away from zero, and a fraction below one half is dropped.
- R5: In minus-infinity mode, the result is the largest integer not greater than the input.
- R6: In toward-zero mode, the fraction is discarded.
- R7: invalid is raised when the exact input, rounded in the selected mode, lies outside the destination range. The signed range is -2^31..2^31-1 and the unsigned range is 0..2^32-1. Examples: nearest-even raises it at max+0.5 and above, and below min-0.5. Toward-zero raises it at max+1 and above, and at min-1 and below.
- R8: When invalid is raised for a non-NaN input, a signed result is 0x80000000 for a negative input and 0x7FFFFFFF otherwise. An unsigned result is 0x00000000 for a negative input and 0xFFFFFFFF otherwise.
- R9: A NaN input raises invalid and returns 0. An infinity raises invalid and saturates by its sign as in R8.
- R10: When is_double is 0, operand[31:0] is read as a single-precision value and operand[63:32] is ignored. When is_double is 1, all 64 bits form a double.
- R11: When force_rz is 0 and rmode is 01, mode_err is 1 and the result is the toward-zero conversion. Otherwise mode_err is 0.
- R12: is_signed 1 selects a signed destination and 0 selects an unsigned one. An unsigned conversion of any negative input returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Request strobe |
| operand | input | 64 | Floating-point operand (single in bits 31:0) |
| is_double | input | 1 | 1: double, 0: single |
| is_signed | input | 1 | 1: signed destination, 0: unsigned |
| force_rz | input | 1 | 1: round toward zero regardless of rmode |
| rmode | input | 2 | Rounding mode field from status bits 23:22 |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 32 | Converted integer |
| invalid | output | 1 | Invalid-operation flag |
| mode_err | output | 1 | Unsupported rounding mode requested |

## Verification
The rounding increment and the range check can act on the same conversion. In that case the carry out of rounding is what pushes the magnitude past a limit. The bench provokes this with inputs placed exactly at each half-step and whole-step threshold: 2147483647.5 and 4294967295.5 under nearest-even, and -0.5 and -0.6 unsigned. Each result is judged on both the invalid flag and the saturated or rounded value. It also sends the unsupported mode code with an input that carries a fraction. The bench then checks that the error flag and the toward-zero result appear in the same cycle.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  localparam int INT_W  = 32;
  localparam int FRAC_W = 52;
  localparam int EXP_W  = 13;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'b00,
    RND_PLUS    = 2'b01,
    RND_MINUS   = 2'b10,
    RND_ZERO    = 2'b11
  } rnd_mode_e;

  typedef struct packed {
    logic                     sign;
    logic signed [EXP_W-1:0]  exp_unb;
    logic [FRAC_W-1:0]        frac;
    logic                     is_nan;
    logic                     is_inf;
    logic                     is_zero;
    logic                     is_tiny;
  } fp_fields_t;
endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
  import fcvt_pkg::*;
(
  input  logic [63:0] operand,
  input  logic        is_double,
  output fp_fields_t  fields
);
  localparam int D_BIAS = 1023;
  localparam int S_BIAS = 127;
  localparam int PAD_W  = FRAC_W - 23;

  always_comb begin
    fields = '0;
    if (is_double) begin
      fields.sign    = operand[63];
      fields.frac    = operand[51:0];
      fields.exp_unb = $signed({2'b00, operand[62:52]}) - EXP_W'(D_BIAS);
      fields.is_nan  = (&operand[62:52]) && (|operand[51:0]);
      fields.is_inf  = (&operand[62:52]) && !(|operand[51:0]);
      fields.is_zero = !(|operand[62:52]) && !(|operand[51:0]);
      fields.is_tiny = !(|operand[62:52]) && (|operand[51:0]);
    end else begin
      fields.sign    = operand[31];
      fields.frac    = {operand[22:0], {PAD_W{1'b0}}};
      fields.exp_unb = $signed({5'b00000, operand[30:23]}) - EXP_W'(S_BIAS);
      fields.is_nan  = (&operand[30:23]) && (|operand[22:0]);
      fields.is_inf  = (&operand[30:23]) && !(|operand[22:0]);
      fields.is_zero = !(|operand[30:23]) && !(|operand[22:0]);
      fields.is_tiny = !(|operand[30:23]) && (|operand[22:0]);
    end
  end
endmodule

// File: rtl/fcvt_round.sv
module fcvt_round
  import fcvt_pkg::*;
(
  input  fp_fields_t          fields,
  input  rnd_mode_e           mode,
  output logic [INT_W+1:0]    rmag,
  output logic                big
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int T_W   = SIG_W + INT_W;

  logic [T_W-1:0]   shifted;
  logic [INT_W:0]   mag;
  logic             guard;
  logic             sticky;
  logic             inc;

  always_comb begin
    shifted = '0;
    mag     = '0;
    guard   = 1'b0;
    sticky  = 1'b0;
    big     = 1'b0;
    if (fields.is_zero || fields.is_nan || fields.is_inf) begin
      mag = '0;
    end else if (fields.is_tiny) begin
      sticky = 1'b1;
    end else if (fields.exp_unb > EXP_W'(INT_W)) begin
      big = 1'b1;
    end else if (fields.exp_unb >= 0) begin
      shifted = {{INT_W{1'b0}}, 1'b1, fields.frac} << fields.exp_unb[5:0];
      mag     = shifted[T_W-1:FRAC_W];
      guard   = shifted[FRAC_W-1];
      sticky  = |shifted[FRAC_W-2:0];
    end else if (fields.exp_unb == -EXP_W'(1)) begin
      guard  = 1'b1;
      sticky = |fields.frac;
    end else begin
      sticky = 1'b1;
    end
  end

  always_comb begin
    unique case (mode)
      RND_NEAREST: inc = guard && (sticky || mag[0]);
      RND_MINUS:   inc = fields.sign && (guard || sticky);
      default:     inc = 1'b0;
    endcase
  end

  assign rmag = {1'b0, mag} + {{(INT_W+1){1'b0}}, inc};
endmodule

// File: rtl/fcvt_to_int.sv
module fcvt_to_int
  import fcvt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [63:0]       operand,
  input  logic              is_double,
  input  logic              is_signed,
  input  logic              force_rz,
  input  logic [1:0]        rmode,
  output logic              out_valid,
  output logic [INT_W-1:0]  result,
  output logic              invalid,
  output logic              mode_err
);
  localparam logic [INT_W+1:0] S_POS_LIM = (INT_W+2)'((64'd1 << (INT_W-1)) - 64'd1);
  localparam logic [INT_W+1:0] S_NEG_LIM = (INT_W+2)'(64'd1 << (INT_W-1));
  localparam logic [INT_W+1:0] U_POS_LIM = (INT_W+2)'((64'd1 << INT_W) - 64'd1);
  localparam logic [INT_W-1:0] S_MAX     = {1'b0, {(INT_W-1){1'b1}}};
  localparam logic [INT_W-1:0] S_MIN     = {1'b1, {(INT_W-1){1'b0}}};

  fp_fields_t        fields;
  rnd_mode_e         eff_mode;
  logic [INT_W+1:0]  rmag;
  logic              big;
  logic              over;
  logic              inv_d;
  logic              err_d;
  logic [INT_W-1:0]  res_d;
  logic              vld_q;
  logic [INT_W-1:0]  res_q;
  logic              inv_q;
  logic              err_q;

  fcvt_unpack u_unpack (
    .operand   (operand),
    .is_double (is_double),
    .fields    (fields)
  );

  always_comb begin
    err_d = 1'b0;
    if (force_rz) begin
      eff_mode = RND_ZERO;
    end else if (rnd_mode_e'(rmode) == RND_PLUS) begin
      eff_mode = RND_ZERO;
      err_d    = 1'b1;
    end else begin
      eff_mode = rnd_mode_e'(rmode);
    end
  end

  fcvt_round u_round (
    .fields (fields),
    .mode   (eff_mode),
    .rmag   (rmag),
    .big    (big)
  );

  always_comb begin
    if (fields.sign) begin
      over = is_signed ? (rmag > S_NEG_LIM) : (rmag != '0);
    end else begin
      over = is_signed ? (rmag > S_POS_LIM) : (rmag > U_POS_LIM);
    end
    over  = over || big || fields.is_inf;
    inv_d = over || fields.is_nan;
    if (fields.is_nan) begin
      res_d = '0;
    end else if (over) begin
      if (is_signed) res_d = fields.sign ? S_MIN : S_MAX;
      else           res_d = fields.sign ? '0 : '1;
    end else if (fields.sign) begin
      res_d = ~rmag[INT_W-1:0] + INT_W'(1);
    end else begin
      res_d = rmag[INT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
      inv_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) begin
        res_q <= res_d;
        inv_q <= inv_d;
        err_q <= err_d;
      end
    end
  end

  assign out_valid = vld_q;
  assign result    = res_q;
  assign invalid   = inv_q;
  assign mode_err  = err_q;
endmodule

// File: rtl/fcvt_to_int_chk.sv
module fcvt_to_int_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] operand,
  input logic        is_double,
  input logic        is_signed,
  input logic        force_rz,
  input logic        out_valid,
  input logic [31:0] result,
  input logic        invalid
);
  logic in_sign;
  assign in_sign = is_double ? operand[63] : operand[31];

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_sat_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && invalid) |-> (result == 32'h0 || result == 32'hFFFF_FFFF ||
                                result == 32'h7FFF_FFFF || result == 32'h8000_0000));
  assert_neg_unsigned_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_signed && in_sign) |=> (result == 32'h0));
  assert_signed_pos_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_signed && !in_sign) |=> (invalid || !result[31]));
endmodule

bind fcvt_to_int fcvt_to_int_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .operand   (operand),
  .is_double (is_double),
  .is_signed (is_signed),
  .force_rz  (force_rz),
  .out_valid (out_valid),
  .result    (result),
  .invalid   (invalid)
);

// File: tb/tb_fcvt_to_int.sv
`timescale 1ns/1ps
module tb_fcvt_to_int;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] operand;
  logic        is_double;
  logic        is_signed;
  logic        force_rz;
  logic [1:0]  rmode;
  logic        out_valid;
  logic [31:0] result;
  logic        invalid;
  logic        mode_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  localparam logic [1:0] MN = 2'b00, MP = 2'b01, MM = 2'b10, MZ = 2'b11;

  fcvt_to_int dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .operand(operand),
    .is_double(is_double), .is_signed(is_signed), .force_rz(force_rz),
    .rmode(rmode), .out_valid(out_valid), .result(result),
    .invalid(invalid), .mode_err(mode_err)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic conv(input string req, input logic [63:0] op, input logic dbl,
                      input logic sgn, input logic frz, input logic [1:0] md,
                      input logic [31:0] exp_res, input logic exp_inv,
                      input logic exp_err);
    @(negedge clk);
    in_valid = 1'b1; operand = op; is_double = dbl; is_signed = sgn;
    force_rz = frz; rmode = md;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " out_valid"}, {31'b0, out_valid}, 32'd1);
    check({req, " result"}, result, exp_res);
    check({req, " invalid"}, {31'b0, invalid}, {31'b0, exp_inv});
    check({req, " mode_err"}, {31'b0, mode_err}, {31'b0, exp_err});
  endtask

  function automatic logic [63:0] d(input real v);
    return $realtobits(v);
  endfunction

  task automatic t_reset();
    check("R1 out_valid", {31'b0, out_valid}, 32'd0);
    check("R1 result", result, 32'd0);
    check("R1 invalid", {31'b0, invalid}, 32'd0);
    check("R1 mode_err", {31'b0, mode_err}, 32'd0);
  endtask

  task automatic t_nearest();
    conv("R4 2.5", d(2.5), 1, 1, 0, MN, 32'd2, 0, 0);
    conv("R4 3.5", d(3.5), 1, 1, 0, MN, 32'd4, 0, 0);
    conv("R4 2.6", d(2.6), 1, 1, 0, MN, 32'd3, 0, 0);
    conv("R4 2.4", d(2.4), 1, 1, 0, MN, 32'd2, 0, 0);
    conv("R4 -2.5", d(-2.5), 1, 1, 0, MN, 32'hFFFF_FFFE, 0, 0);
    conv("R4 -2.6", d(-2.6), 1, 1, 0, MN, 32'hFFFF_FFFD, 0, 0);
    conv("R4 0.5", d(0.5), 1, 1, 0, MN, 32'd0, 0, 0);
  endtask

  task automatic t_minus_zero();
    conv("R5 2.5", d(2.5), 1, 1, 0, MM, 32'd2, 0, 0);
    conv("R5 -2.5", d(-2.5), 1, 1, 0, MM, 32'hFFFF_FFFD, 0, 0);
    conv("R5 -3.0", d(-3.0), 1, 1, 0, MM, 32'hFFFF_FFFD, 0, 0);
    conv("R6 2.9", d(2.9), 1, 1, 0, MZ, 32'd2, 0, 0);
    conv("R6 -2.9", d(-2.9), 1, 1, 0, MZ, 32'hFFFF_FFFE, 0, 0);
    conv("R3 forced 2.9", d(2.9), 1, 1, 1, MN, 32'd2, 0, 0);
    conv("R3 forced -2.9 over RM", d(-2.9), 1, 1, 1, MM, 32'hFFFF_FFFE, 0, 0);
  endtask

  task automatic t_ranges();
    conv("R7 RN s max+0.5", d(2147483647.5), 1, 1, 0, MN, 32'h7FFF_FFFF, 1, 0);
    conv("R7 RN s max+0.4", d(2147483647.4), 1, 1, 0, MN, 32'h7FFF_FFFF, 0, 0);
    conv("R7 RN s min-0.5", d(-2147483648.5), 1, 1, 0, MN, 32'h8000_0000, 0, 0);
    conv("R7 RN s min-0.6", d(-2147483648.6), 1, 1, 0, MN, 32'h8000_0000, 1, 0);
    conv("R7 RN u max+0.5", d(4294967295.5), 1, 0, 0, MN, 32'hFFFF_FFFF, 1, 0);
    conv("R12 RN u -0.5", d(-0.5), 1, 0, 0, MN, 32'd0, 0, 0);
    conv("R7 RN u -0.6", d(-0.6), 1, 0, 0, MN, 32'd0, 1, 0);
    conv("R7 RZ u max+0.9", d(4294967295.9), 1, 0, 0, MZ, 32'hFFFF_FFFF, 0, 0);
    conv("R7 RZ u -0.9", d(-0.9), 1, 0, 0, MZ, 32'd0, 0, 0);
    conv("R7 RZ u -1", d(-1.0), 1, 0, 0, MZ, 32'd0, 1, 0);
    conv("R7 RZ s min-0.9", d(-2147483648.9), 1, 1, 0, MZ, 32'h8000_0000, 0, 0);
    conv("R8 RZ s min-1", d(-2147483649.0), 1, 1, 0, MZ, 32'h8000_0000, 1, 0);
    conv("R8 RZ s max+1", d(2147483648.0), 1, 1, 0, MZ, 32'h7FFF_FFFF, 1, 0);
    conv("R7 RM u -0.1", d(-0.1), 1, 0, 0, MM, 32'd0, 1, 0);
    conv("R7 RM s min", d(-2147483648.0), 1, 1, 0, MM, 32'h8000_0000, 0, 0);
    conv("R8 RM s min-0.5", d(-2147483648.5), 1, 1, 0, MM, 32'h8000_0000, 1, 0);
    conv("R12 u 3e9", d(3.0e9), 1, 0, 0, MZ, 32'd3000000000, 0, 0);
    conv("R12 s 3e9", d(3.0e9), 1, 1, 0, MZ, 32'h7FFF_FFFF, 1, 0);
    conv("R8 u 1e20", d(1.0e20), 1, 0, 0, MZ, 32'hFFFF_FFFF, 1, 0);
  endtask

  task automatic t_special();
    conv("R9 NaN", 64'h7FF8_0000_0000_0000, 1, 1, 0, MN, 32'd0, 1, 0);
    conv("R9 -NaN u", 64'hFFF8_0000_0000_0001, 1, 0, 0, MZ, 32'd0, 1, 0);
    conv("R9 -inf", 64'hFFF0_0000_0000_0000, 1, 1, 0, MZ, 32'h8000_0000, 1, 0);
    conv("R9 +inf u", 64'h7FF0_0000_0000_0000, 1, 0, 0, MN, 32'hFFFF_FFFF, 1, 0);
  endtask

  task automatic t_single();
    conv("R10 s 2.5", {32'hDEAD_BEEF, 32'h4020_0000}, 0, 1, 0, MN, 32'd2, 0, 0);
    conv("R10 s -1.5", {32'h7FF8_0000, 32'hBFC0_0000}, 0, 1, 0, MN, 32'hFFFF_FFFE, 0, 0);
    conv("R10 s 3.0", {32'hFFFF_FFFF, 32'h4040_0000}, 0, 0, 0, MM, 32'd3, 0, 0);
    conv("R10 s NaN", {32'h0000_0000, 32'h7FC0_0000}, 0, 1, 0, MN, 32'd0, 1, 0);
  endtask

  task automatic t_mode_err();
    conv("R11 plus mode 2.9", d(2.9), 1, 1, 0, MP, 32'd2, 0, 1);
    conv("R11 plus mode -2.9", d(-2.9), 1, 1, 0, MP, 32'hFFFF_FFFE, 0, 1);
    conv("R11 forced plus", d(2.9), 1, 1, 1, MP, 32'd2, 0, 0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    @(negedge clk);
    check("R2 idle out_valid", {31'b0, out_valid}, 32'd0);
    check("R2 held result", result, 32'd2);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; operand = '0; is_double = 1'b1;
    is_signed = 1'b1; force_rz = 1'b0; rmode = MN;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_nearest();
    t_minus_zero();
    t_ranges();
    t_special();
    t_single();
    t_mode_err();
    t_idle();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule